// File: doc/BRIEF.md
# Boot Mode Selection Sequencer

This block runs once after every hardware reset and decides how the device starts. It passes a boot-select pin through a two-flop synchronizer and samples it. A low pin picks serial code-update mode at once, and the block reads nothing from flash. A high pin makes the sequencer fetch a 16-bit start pointer from flash, one byte at address 0 and one byte at address 1.

Erased flash reads as all ones, so a pointer of all ones means the flash was never programmed. With the pin high and a blank flash, the sequencer raises a halt request that only a reset can clear. With the pin high and any other pointer, it reports user-code mode and gives the pointer as the start address.

The decision is made once. Mode, start address, halt request and the completion flag then hold their values until the next reset. The flash read port uses a one-cycle request with an address, answered some cycles later by a one-cycle valid with the data byte.

Top module: `boot_mode_seq`

## Requirements
- R1: While reset is asserted and until a decision is made, `boot_mode` is 0 (undecided), and `done`, `halt_req`, `rd_req` and `start_addr` are 0. A reset in the middle of a read returns the block to this state.
- R2: The pin reaches the decision only through a two-stage synchronizer. The sampled level is the one present from reset release. Pin changes after the decision have no effect on any output.
- R3: A sampled pin level of 0 gives `boot_mode` = 1 (code update), `done` = 1 and `start_addr` = 0, and no flash read is ever requested.
- R4: A sampled pin level of 1 causes exactly two reads, each a single-cycle `rd_req` pulse. The first read is at address 0. The second is at address 1 and is issued only after the first has returned `rd_valid`.
- R5: The byte from address 0 is the high byte of the pointer and the byte from address 1 is the low byte. A pointer other than FFFFh gives `boot_mode` = 2 (user code), `start_addr` = pointer and `done` = 1.
- R6: A pointer of FFFFh with the pin at 1 gives `boot_mode` = 3 (halt), `halt_req` = 1, `done` = 1 and `start_addr` = 0.
- R7: Once `done` rises, `done`, `boot_mode`, `start_addr` and `halt_req` stay constant and `rd_req` stays low until reset.
- R8: An `rd_valid` that arrives with no read outstanding, including after the decision, changes no output.
- R9: Only a pointer whose sixteen bits are all one counts as blank. FFFEh, 7FFFh, FF00h and 00FFh are ordinary pointers.
- R10: The sequencer waits for `rd_valid` for any number of cycles and makes no decision before the second byte has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_sel | input | 1 | Asynchronous boot-select pin (0 = code update) |
| rd_req | output | 1 | One-cycle flash read request |
| rd_addr | output | ADDR_W | Flash byte address of the request |
| rd_valid | input | 1 | One-cycle read data valid |
| rd_data | input | DATA_W | Flash read data |
| boot_mode | output | 2 | 0 undecided, 1 code update, 2 user code, 3 halt |
| start_addr | output | 2*DATA_W | User code start pointer |
| halt_req | output | 1 | Blank flash with pin high; held until reset |
| done | output | 1 | Decision made; held until reset |

## Verification
A wrong internal state in this block shows up at the ports soon after it occurs. A state machine that skips a read or reorders the two reads produces a wrong address sequence on `rd_addr` at the very next request, or a byte-swapped `start_addr` as soon as `done` rises. An error in the blank-flash comparison flips the reported mode between user and halt. A synchronizer or counter fault shows as a wrong mode, or as an early or late `done` relative to reset release. A decision register that is not held shows as a change after `done`, or as a late read when a stray `rd_valid` or a pin toggle follows the decision.

// File: rtl/boot_mode_seq.sv
module boot_mode_seq #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boot_sel,
  output logic                  rd_req,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rd_valid,
  input  logic [DATA_W-1:0]     rd_data,
  output logic [1:0]            boot_mode,
  output logic [2*DATA_W-1:0]   start_addr,
  output logic                  halt_req,
  output logic                  done
);

  localparam int PTR_W = 2 * DATA_W;
  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [1:0] M_NONE   = 2'd0;
  localparam logic [1:0] M_UPDATE = 2'd1;
  localparam logic [1:0] M_USER   = 2'd2;
  localparam logic [1:0] M_HALT   = 2'd3;

  typedef enum logic [2:0] {
    ST_SYNC, ST_RD_HI, ST_WT_HI, ST_RD_LO, ST_WT_LO, ST_DECIDE, ST_DONE
  } state_t;

  state_t                 state;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt;
  logic [DATA_W-1:0]      hi_q, lo_q;
  logic                   pin_s;
  logic                   blank;

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign blank   = &{hi_q, lo_q};
  assign rd_req  = (state == ST_RD_HI) || (state == ST_RD_LO);
  assign rd_addr = (state == ST_RD_LO) ? ADDR_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], boot_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_SYNC;
      cnt        <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      boot_mode  <= M_NONE;
      start_addr <= '0;
      halt_req   <= 1'b0;
      done       <= 1'b0;
    end else begin
      case (state)
        ST_SYNC: begin
          if (cnt == CNT_W'(SYNC_STAGES)) begin
            if (!pin_s) begin
              boot_mode <= M_UPDATE;
              done      <= 1'b1;
              state     <= ST_DONE;
            end else begin
              state <= ST_RD_HI;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD_HI: state <= ST_WT_HI;
        ST_WT_HI: if (rd_valid) begin
          hi_q  <= rd_data;
          state <= ST_RD_LO;
        end
        ST_RD_LO: state <= ST_WT_LO;
        ST_WT_LO: if (rd_valid) begin
          lo_q  <= rd_data;
          state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          done  <= 1'b1;
          state <= ST_DONE;
          if (blank) begin
            boot_mode <= M_HALT;
            halt_req  <= 1'b1;
          end else begin
            boot_mode  <= M_USER;
            start_addr <= {hi_q, lo_q};
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r3_no_read_in_update: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_mode == M_UPDATE) |-> !rd_req);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(boot_mode) && $stable(start_addr) && $stable(halt_req)));

  a_r7_no_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  a_r6_halt_mode: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (boot_mode == M_HALT && done && start_addr == '0));

  a_r1_undecided: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (boot_mode == M_NONE && !halt_req));

  a_r10_wait_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WT_HI && !rd_valid) |=> (state == ST_WT_HI && !done));

endmodule

// File: tb/boot_mode_seq_test.sv
module boot_mode_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_sel = 1'b1;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [1:0]  boot_mode;
  logic [15:0] start_addr;
  logic        halt_req;
  logic        done;

  logic        m_valid;
  logic [7:0]  m_data;
  logic        inj = 1'b0;
  logic [7:0]  inj_data = 8'h00;
  logic [7:0]  hi_b, lo_b, lat;
  logic        busy;
  logic [7:0]  wait_cnt;
  logic [23:0] pend_addr;
  logic [23:0] addr_log [0:3];
  int          n_reads;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;

  assign rd_valid = m_valid | inj;
  assign rd_data  = inj ? inj_data : m_data;

  always #4 clk = ~clk;

  boot_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .boot_mode(boot_mode), .start_addr(start_addr), .halt_req(halt_req), .done(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_data <= 8'h00; busy <= 1'b0; wait_cnt <= 8'h0;
      pend_addr <= '0; n_reads <= 0;
    end else begin
      m_valid <= 1'b0;
      if (busy) begin
        if (wait_cnt == 8'h0) begin
          m_valid <= 1'b1;
          m_data  <= (pend_addr == 24'h0) ? hi_b : (pend_addr == 24'h1) ? lo_b : 8'hA5;
          busy    <= 1'b0;
        end else wait_cnt <= wait_cnt - 1'b1;
      end
      if (rd_req) begin
        busy      <= 1'b1;
        wait_cnt  <= lat;
        pend_addr <= rd_addr;
        if (n_reads < 4) addr_log[n_reads] <= rd_addr;
        n_reads   <= n_reads + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin, input logic [7:0] h, input logic [7:0] l, input logic [7:0] lt);
    @(negedge clk);
    rst_n = 1'b0; boot_sel = pin; hi_b = h; lo_b = l; lat = lt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
  endtask

  typedef struct packed {
    logic        pin;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [7:0]  lt;
    logic [1:0]  mode;
    logic [15:0] addr;
    logic        halt;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{1'b0, 8'h12, 8'h34, 8'd0,  2'd1, 16'h0000, 1'b0},
    '{1'b1, 8'h12, 8'h34, 8'd0,  2'd2, 16'h1234, 1'b0},
    '{1'b1, 8'hFF, 8'hFF, 8'd2,  2'd3, 16'h0000, 1'b1},
    '{1'b1, 8'hFF, 8'hFE, 8'd1,  2'd2, 16'hFFFE, 1'b0},
    '{1'b1, 8'h7F, 8'hFF, 8'd5,  2'd2, 16'h7FFF, 1'b0},
    '{1'b1, 8'hFF, 8'h00, 8'd0,  2'd2, 16'hFF00, 1'b0},
    '{1'b1, 8'h00, 8'hFF, 8'd3,  2'd2, 16'h00FF, 1'b0},
    '{1'b1, 8'h00, 8'h00, 8'd0,  2'd2, 16'h0000, 1'b0},
    '{1'b0, 8'hFF, 8'hFF, 8'd1,  2'd1, 16'h0000, 1'b0}
  };

  initial begin
    int n;
    hi_b = 8'h0; lo_b = 8'h0; lat = 8'h0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(boot_mode == 2'd0 && !done && !halt_req && !rd_req && start_addr == 16'h0,
        "R1 reset outputs", {boot_mode, done, halt_req, rd_req}, 32'h0);

    for (int i = 0; i < 9; i++) begin
      do_reset(VEC[i].pin, VEC[i].hi, VEC[i].lo, VEC[i].lt);
      wait_done(n);
      chk(done == 1'b1, "R10 done reached", done, 1);
      chk(boot_mode == VEC[i].mode, VEC[i].pin ? "R5/R6/R9 mode" : "R3 update mode", boot_mode, VEC[i].mode);
      chk(start_addr == VEC[i].addr, "R5 start_addr", start_addr, VEC[i].addr);
      chk(halt_req == VEC[i].halt, "R6 halt_req", halt_req, VEC[i].halt);
      if (VEC[i].pin) begin
        chk(n_reads == 2, "R4 read count", n_reads, 2);
        chk(addr_log[0] == 24'h0 && addr_log[1] == 24'h1, "R4 read order",
            {addr_log[0][7:0], addr_log[1][7:0]}, 32'h0001);
      end else begin
        chk(n_reads == 0, "R3 no reads", n_reads, 0);
      end
      boot_sel = ~boot_sel;
      repeat (6) @(negedge clk);
      // R2 / R7: pin change after decision ignored, outputs held, no more reads
      chk(done && boot_mode == VEC[i].mode && start_addr == VEC[i].addr && halt_req == VEC[i].halt,
          "R2 R7 held after pin toggle", {boot_mode, start_addr}, {VEC[i].mode, VEC[i].addr});
      chk(n_reads == (VEC[i].pin ? 2 : 0), "R7 no reads after done", n_reads, VEC[i].pin ? 2 : 0);
    end

    // R8: stray valid after decision
    do_reset(1'b1, 8'hAB, 8'hCD, 8'd0);
    wait_done(n);
    inj_data = 8'hFF; inj = 1'b1;
    @(negedge clk); @(negedge clk); inj = 1'b0;
    repeat (3) @(negedge clk);
    chk(boot_mode == 2'd2 && start_addr == 16'hABCD && !halt_req, "R8 stray valid ignored",
        start_addr, 16'hABCD);

    // R8: stray valid before any read is outstanding
    do_reset(1'b1, 8'h56, 8'h78, 8'd4);
    inj_data = 8'hFF; inj = 1'b1;
    @(negedge clk); inj = 1'b0;
    wait_done(n);
    chk(start_addr == 16'h5678 && boot_mode == 2'd2, "R8 early stray valid", start_addr, 16'h5678);

    // R10: long latency, no decision until second byte
    do_reset(1'b1, 8'h3C, 8'hC3, 8'd40);
    repeat (30) @(negedge clk);
    chk(!done && boot_mode == 2'd0, "R10 no early decision", {done, boot_mode}, 0);
    chk(n_reads == 1, "R4 second read waits for first", n_reads, 1);
    wait_done(n);
    chk(start_addr == 16'h3CC3, "R10 result after long wait", start_addr, 16'h3CC3);

    // R1: reset during a read
    do_reset(1'b1, 8'h11, 8'h22, 8'd60);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!done && boot_mode == 2'd0 && !rd_req && start_addr == 16'h0, "R1 mid-read reset",
        {done, boot_mode}, 0);
    hi_b = 8'h99; lo_b = 8'h88; lat = 8'd0;
    @(negedge clk); rst_n = 1'b1;
    wait_done(n);
    chk(start_addr == 16'h9988 && boot_mode == 2'd2, "R1 restart after reset", start_addr, 16'h9988);

    // R2: synchronizer latency, decision not before pin passes two flops
    do_reset(1'b0, 8'h0, 8'h0, 8'd0);
    @(negedge clk);
    chk(!done, "R2 no decision one cycle after reset", done, 0);
    wait_done(n);
    chk(boot_mode == 2'd1, "R2 sampled level", boot_mode, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule